// File: doc/BRIEF.md
# Crossroad Traffic Light Sequencer

This block drives the lamps of a two-way intersection: a main road and a side road, each with a red, a green and a yellow lamp. It steps through a fixed cycle of four phases. The main road has a long green and the side road a shorter one. Each green is followed by a yellow before that road turns red. The other road's red-to-green change happens on the same tick, with no all-red gap.

Timing comes from one seconds counter that wraps once per cycle. The counter and the phase register move only on clock edges where the one-second tick enable is high. From the counter value, the block works out for each road how many seconds are left before that road's lamp changes. It gives that number as a BCD tens digit and a BCD units digit, ready for a display driver placed outside the block.

The phase lengths are parameters, with defaults of 40 s main green, 4 s yellow and 20 s side green, which give a 68 s cycle.

Top module: `traffic_seq`

## Requirements
- R1: While `rst` (active high, asynchronous) is high, the block shows phase 0 at once, with no clock edge needed: `lamps` = 6'b010100, the main countdown reads 3/9 and the side countdown reads 4/3.
- R2: On a clock edge where `sec_tick` is low, no output changes.
- R3: The phases follow the fixed order 0, 1, 2, 3 and then back to 0. The lamp codes are:
  - phase 0 = 6'b010100
  - phase 1 = 6'b001100
  - phase 2 = 6'b100010
  - phase 3 = 6'b100001

  Bits [5:3] belong to the main road and bits [2:0] to the side road. Within each group the bit order is red, green, yellow.
- R4: Counted in ticks, the phases last 40, 4, 20 and 4 ticks. The full cycle is 68 ticks.
- R5: The main-road countdown depends on the tick count c since the start of the cycle (0 to 67):
  - 39−c in phase 0
  - 43−c in phase 1
  - 67−c in phases 2 and 3
- R6: The side-road countdown depends on the same tick count c:
  - 43−c in phases 0 and 1
  - 63−c in phase 2
  - 67−c in phase 3
- R7: Each countdown is given as two BCD digits. The tens digit is the value divided by 10 and the units digit is the value modulo 10, so the units digit is never above 9.
- R8: When a road's countdown reads 0, the next tick changes that road's lamp group.
- R9: At every moment, each lamp group has exactly one lamp lit, and at least one road shows red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| sec_tick | input | 1 | One-second advance enable |
| lamps | output | 6 | Lamp vector: main road red/green/yellow in bits [5:3], then side road red/green/yellow in bits [2:0] |
| main_tens | output | 4 | Main-road remaining time, tens digit (BCD) |
| main_units | output | 4 | Main-road remaining time, units digit (BCD) |
| side_tens | output | 4 | Side-road remaining time, tens digit (BCD) |
| side_units | output | 4 | Side-road remaining time, units digit (BCD) |

## Verification
The bench builds the block with its default phase lengths of 40/4/20/4. These lengths are small enough that two full 68-tick cycles can be swept exhaustively, so every counter value, every phase boundary and the wrap from 67 back to 0 are each seen twice.

Idle clock edges are mixed in between ticks to exercise the hold behaviour. A reset is applied in the middle of a cycle and checked asynchronously. The phase lengths are measured from the observed lamp patterns, not taken from the counter.

// File: rtl/traffic_seq.sv
module traffic_seq #(
  parameter int MAIN_GREEN = 40,
  parameter int SIDE_GREEN = 20,
  parameter int YELLOW     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick,
  output logic [5:0] lamps,
  output logic [3:0] main_tens,
  output logic [3:0] main_units,
  output logic [3:0] side_tens,
  output logic [3:0] side_units
);
  localparam int END0  = MAIN_GREEN - 1;
  localparam int END1  = END0 + YELLOW;
  localparam int END2  = END1 + SIDE_GREEN;
  localparam int END3  = END2 + YELLOW;
  localparam int CW    = $clog2(END3 + 1);

  localparam logic [CW-1:0] E0 = CW'(END0);
  localparam logic [CW-1:0] E1 = CW'(END1);
  localparam logic [CW-1:0] E2 = CW'(END2);
  localparam logic [CW-1:0] E3 = CW'(END3);
  localparam logic [CW-1:0] TEN = CW'(10);

  logic [1:0]    phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] phase_end;
  logic [CW-1:0] main_rem;
  logic [CW-1:0] side_rem;

  always_comb begin
    case (phase)
      2'd0: begin phase_end = E0; lamps = 6'b010100; main_rem = E0 - cnt; side_rem = E1 - cnt; end
      2'd1: begin phase_end = E1; lamps = 6'b001100; main_rem = E1 - cnt; side_rem = E1 - cnt; end
      2'd2: begin phase_end = E2; lamps = 6'b100010; main_rem = E3 - cnt; side_rem = E2 - cnt; end
      default: begin phase_end = E3; lamps = 6'b100001; main_rem = E3 - cnt; side_rem = E3 - cnt; end
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (sec_tick) begin
      cnt <= (cnt == E3) ? '0 : cnt + 1'b1;
      if (cnt == phase_end) phase <= phase + 2'd1;
    end
  end

  assign main_tens  = 4'(main_rem / TEN);
  assign main_units = 4'(main_rem % TEN);
  assign side_tens  = 4'(side_rem / TEN);
  assign side_units = 4'(side_rem % TEN);
endmodule

module traffic_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sec_tick,
  input logic [5:0] lamps,
  input logic [3:0] main_tens,
  input logic [3:0] main_units,
  input logic [3:0] side_tens,
  input logic [3:0] side_units
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> ($stable(lamps) && $stable(main_tens) && $stable(main_units)
                   && $stable(side_tens) && $stable(side_units))); // R2
  AST_SEQ_P0: assert property (@(posedge clk) disable iff (rst)
    lamps == 6'b010100 |=> (lamps == 6'b010100 || lamps == 6'b001100)); // R3
  AST_SEQ_P1: assert property (@(posedge clk) disable iff (rst)
    lamps == 6'b001100 |=> (lamps == 6'b001100 || lamps == 6'b100010)); // R3
  AST_SEQ_P2: assert property (@(posedge clk) disable iff (rst)
    lamps == 6'b100010 |=> (lamps == 6'b100010 || lamps == 6'b100001)); // R3
  AST_SEQ_P3: assert property (@(posedge clk) disable iff (rst)
    lamps == 6'b100001 |=> (lamps == 6'b100001 || lamps == 6'b010100)); // R3
  AST_BCD_UNITS: assert property (@(posedge clk) disable iff (rst)
    main_units <= 4'd9 && side_units <= 4'd9); // R7
  AST_MAIN_ZERO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && main_tens == 4'd0 && main_units == 4'd0) |=> lamps[5:3] != $past(lamps[5:3])); // R8
  AST_SIDE_ZERO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && side_tens == 4'd0 && side_units == 4'd0) |=> lamps[2:0] != $past(lamps[2:0])); // R8
  AST_ONE_LAMP_EACH: assert property (@(posedge clk) disable iff (rst)
    $countones(lamps[5:3]) == 1 && $countones(lamps[2:0]) == 1); // R9
  AST_ONE_RED: assert property (@(posedge clk) disable iff (rst)
    lamps[5] || lamps[2]); // R9
endmodule

bind traffic_seq traffic_seq_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .lamps(lamps),
  .main_tens(main_tens), .main_units(main_units),
  .side_tens(side_tens), .side_units(side_units)
);

// File: tb/traffic_seq_tb.sv
`timescale 1ns/1ps
module traffic_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [5:0] lamps;
  logic [3:0] main_tens, main_units, side_tens, side_units;

  int checks = 0;
  int failures = 0;
  int k = 0;
  bit done = 0;
  int seen[4] = '{0, 0, 0, 0};

  traffic_seq u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .lamps(lamps),
    .main_tens(main_tens), .main_units(main_units),
    .side_tens(side_tens), .side_units(side_units)
  );

  always #2.5 clk = ~clk;

  function automatic int ph(int c);
    if (c <= 39) return 0;
    if (c <= 43) return 1;
    if (c <= 63) return 2;
    return 3;
  endfunction

  function automatic logic [5:0] exp_lamps(int c);
    case (ph(c))
      0: return 6'b010100;
      1: return 6'b001100;
      2: return 6'b100010;
      default: return 6'b100001;
    endcase
  endfunction

  function automatic int exp_main(int c);
    case (ph(c))
      0: return 39 - c;
      1: return 43 - c;
      default: return 67 - c;
    endcase
  endfunction

  function automatic int exp_side(int c);
    case (ph(c))
      0, 1: return 43 - c;
      2: return 63 - c;
      default: return 67 - c;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (k=%0d)", req, act, exp, k);
    end
  endtask

  task automatic check_all(string tag);
    int m = exp_main(k);
    int s = exp_side(k);
    chk(lamps == exp_lamps(k), {tag, " R3 lamps"}, lamps, exp_lamps(k));
    chk(main_tens == 4'(m / 10) && main_units == 4'(m % 10), {tag, " R5 R7 main"},
        main_tens * 10 + main_units, m);
    chk(side_tens == 4'(s / 10) && side_units == 4'(s % 10), {tag, " R6 R7 side"},
        side_tens * 10 + side_units, s);
    chk(lamps[5] || lamps[2], {tag, " R9 one red"}, lamps, 0);
  endtask

  task automatic step(bit t);
    @(negedge clk);
    sec_tick = t;
    @(posedge clk);
    if (t) k = (k + 1) % 68;
    @(negedge clk);
    sec_tick = 1'b0;
    check_all(t ? "tick" : "R2 idle");
    if (t) begin
      case (lamps)
        6'b010100: seen[0]++;
        6'b001100: seen[1]++;
        6'b100010: seen[2]++;
        6'b100001: seen[3]++;
        default: ;
      endcase
      if (k == 40 || k == 44 || k == 64 || k == 0)
        chk(exp_lamps(k) != exp_lamps((k + 67) % 68), "R8 change after zero", lamps, exp_lamps(k));
    end
  endtask

  initial begin
    #1;
    chk(lamps == 6'b010100, "R1 reset lamps", lamps, 6'b010100);
    chk(main_tens == 3 && main_units == 9, "R1 reset main", main_tens * 10 + main_units, 39);
    chk(side_tens == 4 && side_units == 3, "R1 reset side", side_tens * 10 + side_units, 43);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    k = 0;
    for (int i = 0; i < 136; i++) begin
      step(1'b1);
      if (i % 17 == 5) step(1'b0);
      if (k == 39) chk(main_tens == 0 && main_units == 0, "R8 main reads zero", main_units, 0);
    end
    chk(seen[0] == 80, "R4 main green ticks", seen[0], 80);
    chk(seen[1] == 8,  "R4 main yellow ticks", seen[1], 8);
    chk(seen[2] == 40, "R4 side green ticks", seen[2], 40);
    chk(seen[3] == 8,  "R4 side yellow ticks", seen[3], 8);
    chk(k == 0, "R4 cycle length", k, 0);
    for (int i = 0; i < 50; i++) step(1'b1);
    @(negedge clk);
    #1 rst = 1'b1;
    #0.5;
    k = 0;
    chk(lamps == 6'b010100, "R1 mid-cycle reset lamps", lamps, 6'b010100);
    chk(main_tens == 3 && main_units == 9, "R1 mid-cycle reset main", main_tens * 10 + main_units, 39);
    chk(side_tens == 4 && side_units == 3, "R1 mid-cycle reset side", side_tens * 10 + side_units, 43);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 45; i++) step(1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule